// File: doc/BRIEF.md
# Transport Stream Input Framer

This block is the receive front end of a cable modulator. It takes an MPEG-2 transport stream from an 8-bit data port, clocked in by a per-item strobe, and turns it into aligned bytes marked with a packet-start flag. The port carries one bit per strobe on line 0 in serial mode, or a whole byte per strobe in parallel mode.

Packet boundaries come from one of two sources. The first is a pulse on a frame-start input. The second is a search for the 0x47 sync byte repeating every 188 bytes. In the search case, lock is gained after repeated hits and is dropped after repeated misses. When lock is held, the framer can rewrite the sync byte that opens each group of eight packets to 0xB8.

Three configuration bits select these modes. They sit in a small register that has fixed reset values and is loaded by a write strobe. Every write restarts alignment from scratch.

Top module: `ts_framer`

## Requirements
- R1: After reset the configuration is parallel capture, sync-byte alignment and sync rewrite enabled. A cycle with cfg_we high loads cfg_serial, cfg_ext_align and cfg_sync_swap and restarts alignment. No byte is output straight after reset.
- R2: In parallel mode (cfg_serial=0), each cycle with din_stb high captures din[7:0] as one byte.
- R3: In serial mode (cfg_serial=1), each cycle with din_stb high captures one bit from din[0]. Bits arrive most significant first, and eight bits form a byte.
- R4: In sync-byte mode (cfg_ext_align=0), lock is declared on the third 0x47 byte in a row found at 188-byte spacing. That byte is the first one output, and no byte is output before it.
- R5: While locked in sync-byte mode, a packet whose first byte is not 0x47 is still output in full with out_sop. A second consecutive miss drops lock: that byte and all later bytes are withheld until lock is gained again as in R4.
- R6: In external mode (cfg_ext_align=1), a frame_start pulse given with a strobe marks the first byte (parallel) or the first bit of the first byte (serial) of a packet. Output starts with that byte, and the packet's first byte is passed whatever its value. Nothing is output before the first pulse.
- R7: With cfg_sync_swap=1, the first byte of the first packet after lock, and of every eighth packet after it, is output as 0xB8. The first bytes of all other packets are output unchanged.
- R8: With cfg_sync_swap=0, every first byte is output unchanged.
- R9: Each output byte is shown for one cycle with out_valid high. out_sop is high exactly with the first byte of each 188-byte packet. Payload bytes are output unchanged and in order.
- R10: In serial sync-byte mode, byte alignment is found from the 0x47 bit pattern at any bit offset in the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Load configuration and restart alignment |
| cfg_serial | input | 1 | 1: bit-serial capture on din[0]; 0: byte-parallel capture |
| cfg_ext_align | input | 1 | 1: align on frame_start; 0: search for the sync byte |
| cfg_sync_swap | input | 1 | 1: rewrite the group-leading sync byte to 0xB8 |
| din | input | 8 | Stream data |
| din_stb | input | 1 | One bit or byte is present on din |
| frame_start | input | 1 | Packet start pulse, read with din_stb |
| out_byte | output | 8 | Aligned output byte |
| out_valid | output | 1 | out_byte is valid this cycle |
| out_sop | output | 1 | out_byte is the first byte of a packet |

## Verification
The assertions assume that the configuration is written only while the stream is idle and the pipeline is empty. They also assume that frame_start is raised only together with din_stb, and that a serial stream under search holds no stray 0x47 bit pattern before its first real sync byte. The stimulus meets these conditions: it waits for the output to drain before each configuration write and starts every serial search stream on a sync byte or on zero bits. All payload bytes lie between 0x80 and 0xBF, so they never imitate a sync byte. Missing sync bytes are produced by sending 0x00 where the sync byte should be.

// File: rtl/ts_framer_pkg.sv
package ts_framer_pkg;

    localparam int unsigned    PKT_LEN_D    = 188;
    localparam int unsigned    GROUP_LEN_D  = 8;
    localparam int unsigned    LOCK_HITS_D  = 3;
    localparam int unsigned    MISS_LIMIT_D = 2;
    localparam logic [7:0]     SYNC_BYTE    = 8'h47;
    localparam logic [7:0]     ALT_SYNC     = 8'hB8;

    typedef struct packed {
        logic serial;
        logic ext_align;
        logic sync_swap;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{serial: 1'b0, ext_align: 1'b0, sync_swap: 1'b1};

    // byte leaving the deserializer
    typedef struct packed {
        logic [7:0] data;
        logic       valid;
        logic       mark;
    } raw_beat_t;

    // byte leaving the aligner
    typedef struct packed {
        logic [7:0] data;
        logic       valid;
        logic       sop;
        logic       first;
    } pkt_beat_t;

    typedef enum logic [1:0] {AL_SEARCH, AL_VERIFY, AL_LOCK} align_state_e;

    function automatic logic [7:0] shift_in(input logic [7:0] w, input logic b);
        return {w[6:0], b};
    endfunction

endpackage

// File: rtl/ts_deser.sv
module ts_deser
    import ts_framer_pkg::*;
#(
    parameter logic [7:0] SYNC = SYNC_BYTE
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       flush,
    input  logic       serial,
    input  logic       hunt_req,
    input  logic [7:0] din,
    input  logic       din_stb,
    input  logic       frame_start,
    output raw_beat_t  o_beat
);

    logic [7:0] win;
    logic [2:0] cnt;
    logic       hunting;
    logic       hunt_req_q;
    logic       mark_pend;

    logic [7:0] win_n;
    logic [2:0] cnt_base;
    logic       hunt_mode;
    logic       ser_emit;

    always_comb begin
        win_n     = shift_in(win, din[0]);
        cnt_base  = frame_start ? 3'd0 : cnt;
        hunt_mode = hunting && hunt_req;
        ser_emit  = hunt_mode ? (win_n == SYNC) : (cnt_base == 3'd7);
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            win        <= '0;
            cnt        <= '0;
            hunting    <= 1'b1;
            hunt_req_q <= 1'b1;
            mark_pend  <= 1'b0;
            o_beat     <= '0;
        end else begin
            hunt_req_q   <= hunt_req;
            o_beat.valid <= 1'b0;
            o_beat.mark  <= 1'b0;
            if (hunt_req && !hunt_req_q) begin
                hunting <= 1'b1;
            end
            if (din_stb) begin
                if (serial) begin
                    win <= win_n;
                    if (ser_emit) begin
                        o_beat    <= '{data: win_n, valid: 1'b1, mark: frame_start | mark_pend};
                        cnt       <= '0;
                        mark_pend <= 1'b0;
                        if (hunt_mode) begin
                            hunting <= 1'b0;
                        end
                    end else begin
                        cnt       <= cnt_base + 3'd1;
                        mark_pend <= frame_start ? 1'b1 : mark_pend;
                    end
                end else begin
                    o_beat <= '{data: din, valid: 1'b1, mark: frame_start};
                end
            end
        end
    end

    // R2: a parallel strobe yields exactly the sampled byte one cycle later
    p_par_capture_r2: assert property (@(posedge clk) disable iff (rst)
        (!serial && din_stb && !flush) |=> (o_beat.valid && o_beat.data == $past(din)));

    // R10: while hunting for bit alignment only the sync pattern is released
    p_hunt_sync_only_r10: assert property (@(posedge clk) disable iff (rst)
        (hunting && hunt_req && serial && din_stb && !flush) |=> (!o_beat.valid || o_beat.data == SYNC));

endmodule

// File: rtl/ts_align.sv
module ts_align
    import ts_framer_pkg::*;
#(
    parameter int unsigned PKT_LEN    = PKT_LEN_D,
    parameter int unsigned GROUP_LEN  = GROUP_LEN_D,
    parameter int unsigned LOCK_HITS  = LOCK_HITS_D,
    parameter int unsigned MISS_LIMIT = MISS_LIMIT_D,
    parameter logic [7:0]  SYNC       = SYNC_BYTE
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       flush,
    input  logic       ext_align,
    input  raw_beat_t  i_beat,
    output logic       hunt_req,
    output pkt_beat_t  o_beat
);

    localparam int unsigned POS_W  = $clog2(PKT_LEN);
    localparam int unsigned GRP_W  = (GROUP_LEN > 1) ? $clog2(GROUP_LEN) : 1;
    localparam int unsigned HIT_W  = $clog2(LOCK_HITS + 1);
    localparam int unsigned MISS_W = $clog2(MISS_LIMIT + 1);
    localparam logic [POS_W-1:0]  LAST_POS  = POS_W'(PKT_LEN - 1);
    localparam logic [GRP_W-1:0]  LAST_GRP  = GRP_W'(GROUP_LEN - 1);
    localparam logic [HIT_W-1:0]  HIT_LAST  = HIT_W'(LOCK_HITS - 1);
    localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(MISS_LIMIT - 1);

    align_state_e       state;
    logic [POS_W-1:0]   pos;
    logic [HIT_W-1:0]   hits;
    logic [MISS_W-1:0]  miss;
    logic [GRP_W-1:0]   grp;

    logic [POS_W-1:0]   pos_nx;
    logic [GRP_W-1:0]   grp_nx;
    logic               is_sync;
    logic               at_head;

    always_comb begin
        pos_nx   = (pos == LAST_POS) ? '0 : pos + 1'b1;
        grp_nx   = (grp == LAST_GRP) ? '0 : grp + 1'b1;
        is_sync  = (i_beat.data == SYNC);
        at_head  = (pos == '0);
        hunt_req = (state == AL_SEARCH) && !ext_align;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            state  <= AL_SEARCH;
            pos    <= '0;
            hits   <= '0;
            miss   <= '0;
            grp    <= '0;
            o_beat <= '0;
        end else begin
            o_beat.valid <= 1'b0;
            o_beat.sop   <= 1'b0;
            o_beat.first <= 1'b0;
            o_beat.data  <= i_beat.data;
            if (i_beat.valid) begin
                if (ext_align) begin
                    if (i_beat.mark) begin
                        state        <= AL_LOCK;
                        pos          <= POS_W'(1);
                        grp          <= (state == AL_LOCK) ? grp_nx : '0;
                        o_beat.valid <= 1'b1;
                        o_beat.sop   <= 1'b1;
                        o_beat.first <= (state == AL_LOCK) ? (grp_nx == '0) : 1'b1;
                    end else if (state == AL_LOCK) begin
                        pos          <= pos_nx;
                        o_beat.valid <= 1'b1;
                        if (at_head) begin
                            grp          <= grp_nx;
                            o_beat.sop   <= 1'b1;
                            o_beat.first <= (grp_nx == '0);
                        end
                    end
                end else begin
                    unique case (state)
                        AL_SEARCH: begin
                            if (is_sync) begin
                                state <= AL_VERIFY;
                                hits  <= HIT_W'(1);
                                pos   <= POS_W'(1);
                            end
                        end
                        AL_VERIFY: begin
                            if (at_head) begin
                                pos <= POS_W'(1);
                                if (!is_sync) begin
                                    state <= AL_SEARCH;
                                end else if (hits == HIT_LAST) begin
                                    state        <= AL_LOCK;
                                    miss         <= '0;
                                    grp          <= '0;
                                    o_beat.valid <= 1'b1;
                                    o_beat.sop   <= 1'b1;
                                    o_beat.first <= 1'b1;
                                end else begin
                                    hits <= hits + 1'b1;
                                end
                            end else begin
                                pos <= pos_nx;
                            end
                        end
                        AL_LOCK: begin
                            pos <= pos_nx;
                            if (at_head) begin
                                if (!is_sync && miss == MISS_LAST) begin
                                    state <= AL_SEARCH;
                                    pos   <= '0;
                                end else begin
                                    miss         <= is_sync ? '0 : miss + 1'b1;
                                    grp          <= grp_nx;
                                    o_beat.valid <= 1'b1;
                                    o_beat.sop   <= 1'b1;
                                    o_beat.first <= (grp_nx == '0);
                                end
                            end else begin
                                o_beat.valid <= 1'b1;
                            end
                        end
                        default: state <= AL_SEARCH;
                    endcase
                end
            end
        end
    end

    // R4: search-mode lock is only reached after the full run of hits
    p_lock_entry_r4: assert property (@(posedge clk) disable iff (rst)
        ($rose(state == AL_LOCK) && !ext_align) |-> ($past(hits) == HIT_LAST && $past(is_sync)));

    // R5: the consecutive-miss count never reaches the drop limit while held
    p_miss_bound_r5: assert property (@(posedge clk) disable iff (rst)
        miss <= MISS_LAST);

    // R9: byte position stays inside one packet
    p_pos_bound_r9: assert property (@(posedge clk) disable iff (rst)
        pos <= LAST_POS);

    // R6: a frame mark in external mode always opens an output packet
    p_ext_mark_r6: assert property (@(posedge clk) disable iff (rst)
        (ext_align && i_beat.valid && i_beat.mark && !flush) |=> (o_beat.valid && o_beat.sop));

endmodule

// File: rtl/ts_sync_rewrite.sv
module ts_sync_rewrite
    import ts_framer_pkg::*;
#(
    parameter logic [7:0] REPL = ALT_SYNC
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       flush,
    input  logic       sync_swap,
    input  pkt_beat_t  i_beat,
    output logic [7:0] out_byte,
    output logic       out_valid,
    output logic       out_sop
);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            out_byte  <= '0;
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
        end else begin
            out_valid <= i_beat.valid;
            out_sop   <= i_beat.valid && i_beat.sop;
            if (i_beat.valid) begin
                out_byte <= (sync_swap && i_beat.sop && i_beat.first) ? REPL : i_beat.data;
            end
        end
    end

    // R9: packet start only ever appears on a valid byte
    p_sop_valid_r9: assert property (@(posedge clk) disable iff (rst)
        out_sop |-> out_valid);

    // R9: payload bytes leave untouched
    p_payload_pass_r9: assert property (@(posedge clk) disable iff (rst)
        (i_beat.valid && !i_beat.sop && !flush) |=> (out_valid && out_byte == $past(i_beat.data)));

    // R7: the group-leading start byte is rewritten
    p_group_rewrite_r7: assert property (@(posedge clk) disable iff (rst)
        (i_beat.valid && i_beat.sop && i_beat.first && sync_swap && !flush) |=> (out_byte == REPL));

    // R8: with rewriting off every byte passes
    p_no_rewrite_r8: assert property (@(posedge clk) disable iff (rst)
        (i_beat.valid && !sync_swap && !flush) |=> (out_byte == $past(i_beat.data)));

endmodule

// File: rtl/ts_framer.sv
module ts_framer
    import ts_framer_pkg::*;
#(
    parameter int unsigned PKT_LEN    = PKT_LEN_D,
    parameter int unsigned GROUP_LEN  = GROUP_LEN_D,
    parameter int unsigned LOCK_HITS  = LOCK_HITS_D,
    parameter int unsigned MISS_LIMIT = MISS_LIMIT_D
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  logic       cfg_serial,
    input  logic       cfg_ext_align,
    input  logic       cfg_sync_swap,
    input  logic [7:0] din,
    input  logic       din_stb,
    input  logic       frame_start,
    output logic [7:0] out_byte,
    output logic       out_valid,
    output logic       out_sop
);

    cfg_t      cfg_q;
    raw_beat_t raw_beat;
    pkt_beat_t pkt_beat;
    logic      hunt_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (cfg_we) begin
            cfg_q <= '{serial: cfg_serial, ext_align: cfg_ext_align, sync_swap: cfg_sync_swap};
        end
    end

    ts_deser #(.SYNC(SYNC_BYTE)) u_deser (
        .clk         (clk),
        .rst         (rst),
        .flush       (cfg_we),
        .serial      (cfg_q.serial),
        .hunt_req    (hunt_req),
        .din         (din),
        .din_stb     (din_stb),
        .frame_start (frame_start),
        .o_beat      (raw_beat)
    );

    ts_align #(
        .PKT_LEN    (PKT_LEN),
        .GROUP_LEN  (GROUP_LEN),
        .LOCK_HITS  (LOCK_HITS),
        .MISS_LIMIT (MISS_LIMIT),
        .SYNC       (SYNC_BYTE)
    ) u_align (
        .clk       (clk),
        .rst       (rst),
        .flush     (cfg_we),
        .ext_align (cfg_q.ext_align),
        .i_beat    (raw_beat),
        .hunt_req  (hunt_req),
        .o_beat    (pkt_beat)
    );

    ts_sync_rewrite #(.REPL(ALT_SYNC)) u_rewrite (
        .clk       (clk),
        .rst       (rst),
        .flush     (cfg_we),
        .sync_swap (cfg_q.sync_swap),
        .i_beat    (pkt_beat),
        .out_byte  (out_byte),
        .out_valid (out_valid),
        .out_sop   (out_sop)
    );

    // R1: the configuration register holds its reset value until written
    p_cfg_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(cfg_we) |-> $stable(cfg_q));

endmodule

// File: tb/tb_ts_framer.sv
module tb_ts_framer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic       cfg_serial = 1'b0;
    logic       cfg_ext_align = 1'b0;
    logic       cfg_sync_swap = 1'b0;
    logic [7:0] din = '0;
    logic       din_stb = 1'b0;
    logic       frame_start = 1'b0;
    logic [7:0] out_byte;
    logic       out_valid;
    logic       out_sop;

    int  errors = 0;
    int  checks = 0;
    bit  ser = 1'b0;
    bit  done = 1'b0;

    logic [8:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    ts_framer dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_serial(cfg_serial),
        .cfg_ext_align(cfg_ext_align), .cfg_sync_swap(cfg_sync_swap),
        .din(din), .din_stb(din_stb), .frame_start(frame_start),
        .out_byte(out_byte), .out_valid(out_valid), .out_sop(out_sop)
    );

    function automatic logic [7:0] pay(input int p, input int i);
        return 8'h80 | 8'((p * 5 + i) % 64);
    endfunction

    // monitor: pops the scoreboard as bytes appear
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R4 unexpected output: actual sop=%0b byte=%02h expected none", out_sop, out_byte);
            end else begin
                logic [8:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({out_sop, out_byte} !== e) begin
                    errors++;
                    $display("FAIL %s: actual sop=%0b byte=%02h expected sop=%0b byte=%02h",
                             t, out_sop, out_byte, e[8], e[7:0]);
                end
            end
        end
    end

    task automatic put_byte(input logic [7:0] b, input logic fs);
        if (!ser) begin
            @(negedge clk);
            din = b; din_stb = 1'b1; frame_start = fs;
            @(negedge clk);
            din_stb = 1'b0; frame_start = 1'b0;
        end else begin
            for (int k = 7; k >= 0; k--) begin
                @(negedge clk);
                din = {7'b0, b[k]}; din_stb = 1'b1; frame_start = fs && (k == 7);
                @(negedge clk);
                din_stb = 1'b0; frame_start = 1'b0;
            end
        end
    endtask

    task automatic put_bit(input logic b);
        @(negedge clk);
        din = {7'b0, b}; din_stb = 1'b1;
        @(negedge clk);
        din_stb = 1'b0;
    endtask

    task automatic send_pkt(input logic [7:0] s, input int p, input bit fs,
                            input bit expo, input logic [7:0] exp_s, input string tag);
        if (expo) begin exp_q.push_back({1'b1, exp_s}); tag_q.push_back(tag); end
        put_byte(s, fs);
        for (int i = 1; i < 188; i++) begin
            if (expo) begin exp_q.push_back({1'b0, pay(p, i)}); tag_q.push_back("R9 payload"); end
            put_byte(pay(p, i), 1'b0);
        end
    endtask

    task automatic set_cfg(input bit s, input bit e, input bit r);
        @(negedge clk);
        cfg_serial = s; cfg_ext_align = e; cfg_sync_swap = r; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        ser = s;
    endtask

    task automatic drain(input string tag);
        repeat (12) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s: actual pending=%0d expected pending=0", tag, exp_q.size());
            exp_q.delete(); tag_q.delete();
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_sop !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset outputs: actual valid=%0b sop=%0b expected 0 0", out_valid, out_sop);
        end

        // default config (R1): parallel, sync search, rewrite on
        for (int g = 0; g < 3; g++) put_byte(8'h00, 1'b0);
        send_pkt(8'h47, 0, 0, 0, 8'h00, "");
        send_pkt(8'h47, 1, 0, 0, 8'h00, "");
        send_pkt(8'h47, 2, 0, 1, 8'hB8, "R1 R4 R7 first locked");
        for (int p = 3; p < 10; p++) send_pkt(8'h47, p, 0, 1, 8'h47, "R7 R2 mid group");
        send_pkt(8'h47, 10, 0, 1, 8'hB8, "R7 ninth packet");
        send_pkt(8'h00, 11, 0, 1, 8'h00, "R5 first miss kept");
        send_pkt(8'h00, 12, 0, 0, 8'h00, "");
        send_pkt(8'h47, 13, 0, 0, 8'h00, "");
        send_pkt(8'h47, 14, 0, 0, 8'h00, "");
        send_pkt(8'h47, 15, 0, 1, 8'hB8, "R5 R4 relock");
        send_pkt(8'h47, 16, 0, 1, 8'h47, "R5 after relock");
        drain("R5 drain");

        // rewrite off
        set_cfg(1'b0, 1'b0, 1'b0);
        send_pkt(8'h47, 20, 0, 0, 8'h00, "");
        send_pkt(8'h47, 21, 0, 0, 8'h00, "");
        send_pkt(8'h47, 22, 0, 1, 8'h47, "R8 group lead unchanged");
        send_pkt(8'h47, 23, 0, 1, 8'h47, "R8 passthrough");
        drain("R8 drain");

        // external alignment, parallel
        set_cfg(1'b0, 1'b1, 1'b1);
        put_byte(8'h47, 1'b0);
        put_byte(8'h33, 1'b0);
        send_pkt(8'h47, 30, 1, 1, 8'hB8, "R6 first pulse");
        send_pkt(8'h12, 31, 1, 1, 8'h12, "R6 content ignored");
        for (int p = 32; p < 38; p++) send_pkt(8'h47, p, 1, 1, 8'h47, "R7 ext group");
        send_pkt(8'h47, 38, 1, 1, 8'hB8, "R7 ext ninth");
        drain("R6 drain");

        // serial, sync search, misaligned start
        set_cfg(1'b1, 1'b0, 1'b1);
        for (int k = 0; k < 3; k++) put_bit(1'b0);
        send_pkt(8'h47, 40, 0, 0, 8'h00, "");
        send_pkt(8'h47, 41, 0, 0, 8'h00, "");
        send_pkt(8'h47, 42, 0, 1, 8'hB8, "R10 R3 serial lock");
        send_pkt(8'h47, 43, 0, 1, 8'h47, "R3 serial");
        drain("R10 drain");

        // serial, external alignment, rewrite off
        set_cfg(1'b1, 1'b1, 1'b0);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
        send_pkt(8'h47, 50, 1, 1, 8'h47, "R6 R3 serial pulse");
        send_pkt(8'h47, 51, 1, 1, 8'h47, "R6 R8 serial");
        drain("R3 drain");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule